// File: doc/BRIEF.md
# Multi-Thread Commit Thread Selector

This block decides which hardware thread gets the next commit slot in a multi-threaded out-of-order core. For every thread it receives an active flag, a three-bit commit status, a "reorder buffer empty" flag, a "head instruction ready" flag and the sequence number of the head instruction. From these it produces a valid flag and a thread index. The commit stage asks for one grant at a time, as many times per cycle as its commit width allows.

A static two-bit policy input picks the arbitration rule. In the oldest-head policy, and in the aggressive policy that behaves the same way, the grant goes to the candidate with the smallest head sequence number. In the rotating policy the block keeps an ordered list of thread indices. It grants the first candidate in that list and moves the granted thread to the back of the list. The list update takes effect at a single clock edge, so the next request already sees the new order. When the block is built for one thread, it only checks that thread's active flag and status.

Top module: `commit_thread_sel`

## Requirements
- R1: A thread can be granted only while its active flag is high and its status code is Idle (0), Running (1) or FetchTrapPending (4). Codes ROB-squashing (2), TrapPending (3) and 5 to 7 are never granted.
- R2: With more than one thread, a thread is a candidate only if it also has its empty flag low and its head-ready flag high.
- R3: Under policy code 2 (oldest-head), and under code 3, the grant is the candidate with the smallest head sequence number, compared as unsigned. On equal sequence numbers the lower thread index wins.
- R4: Policy code 0 (aggressive) grants exactly the same thread as the oldest-head policy.
- R5: Under policy code 1 (rotating), the grant is the first candidate met when the priority list is scanned from its front.
- R6: After reset the priority list holds the thread indices in ascending order, 0 at the front.
- R7: At a clock edge where the request input is high, the policy is rotating and a grant is valid, the granted thread moves to the back of the list. Threads that were behind it each move up one place, and threads ahead of it keep their places. The new order is used from the next cycle on.
- R8: The priority list does not change when the request input is low, when the policy is not rotating, or when no grant is valid.
- R9: With one thread configured, thread 0 is granted whenever R1 holds for it, whatever its empty and head-ready flags are.
- R10: When no thread qualifies, the valid output is low and the thread index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Arbitration policy: 0 aggressive, 1 rotating, 2 oldest-head, 3 as oldest-head |
| req_i | input | 1 | A grant is being consumed at this edge |
| active_i | input | NUM_THREADS | Per-thread active flag |
| status_i | input | NUM_THREADS x 3 | Per-thread commit status code |
| empty_i | input | NUM_THREADS | Per-thread reorder buffer empty flag |
| head_rdy_i | input | NUM_THREADS | Per-thread head instruction ready flag |
| head_seq_i | input | NUM_THREADS x SEQ_W | Per-thread head sequence number |
| grant_vld_o | output | 1 | A thread is granted |
| grant_tid_o | output | TID_W | Granted thread index (0 when no grant) |

## Verification
The bench builds two copies of the block. One uses four threads and 16-bit sequence numbers, which brings in list rotation from every position, ties between sequence numbers and mixes of candidates and non-candidates. The other uses a single thread, which brings in the variant that ignores the empty and head-ready flags. Small random sequence ranges are used so that equal head sequence numbers occur often. Policy changes happen part-way through a run, which shows that the list is kept while another policy is selected.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RUNNING    = 3'd1,
        ST_ROB_SQUASH = 3'd2,
        ST_TRAP_WAIT  = 3'd3,
        ST_FETCH_TRAP = 3'd4
    } cstat_e;

    typedef enum logic [1:0] {
        POL_AGGRESSIVE = 2'd0,
        POL_ROTATE     = 2'd1,
        POL_OLDEST     = 2'd2,
        POL_SPARE      = 2'd3
    } cpol_e;

    localparam int STATUS_W = 3;

    // Status codes that allow a thread to take a commit slot
    function automatic logic status_can_commit(input logic [STATUS_W-1:0] code);
        return (code == ST_IDLE) || (code == ST_RUNNING) || (code == ST_FETCH_TRAP);
    endfunction

    function automatic int tid_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/csel_elig.sv
module csel_elig
    import csel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter bit NEED_HEAD   = 1'b1
) (
    input  logic [NUM_THREADS-1:0]               active_i,
    input  logic [NUM_THREADS-1:0][STATUS_W-1:0] status_i,
    input  logic [NUM_THREADS-1:0]               empty_i,
    input  logic [NUM_THREADS-1:0]               head_rdy_i,
    output logic [NUM_THREADS-1:0]               cand_o
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic state_ok;
        assign state_ok = active_i[t] && status_can_commit(status_i[t]);
        if (NEED_HEAD) begin : g_head
            assign cand_o[t] = state_ok && !empty_i[t] && head_rdy_i[t];
        end else begin : g_nohead
            assign cand_o[t] = state_ok;
        end
    end
endmodule

// File: rtl/csel_oldest.sv
module csel_oldest #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]            cand_i,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0] seq_i,
    output logic                              vld_o,
    output logic [TID_W-1:0]                  tid_o
);
    logic [SEQ_W-1:0] best_seq;

    // Linear scan; strict compare keeps the lower index on ties
    always_comb begin
        vld_o    = 1'b0;
        tid_o    = '0;
        best_seq = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (cand_i[t] && (!vld_o || (seq_i[t] < best_seq))) begin
                vld_o    = 1'b1;
                tid_o    = TID_W'(t);
                best_seq = seq_i[t];
            end
        end
    end
endmodule

// File: rtl/csel_rr.sv
module csel_rr #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   advance_i,
    input  logic [NUM_THREADS-1:0] cand_i,
    output logic                   vld_o,
    output logic [TID_W-1:0]       tid_o
);
    logic [NUM_THREADS-1:0][TID_W-1:0] ord_q;
    logic [NUM_THREADS-1:0][TID_W-1:0] ord_nxt;
    logic [TID_W-1:0]                  pos;

    // Scan the list from its front
    always_comb begin
        vld_o = 1'b0;
        tid_o = '0;
        pos   = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            if (!vld_o && (int'(ord_q[k]) < NUM_THREADS) && cand_i[ord_q[k]]) begin
                vld_o = 1'b1;
                tid_o = ord_q[k];
                pos   = TID_W'(k);
            end
        end
    end

    // Granted entry goes to the back, entries behind it move up
    always_comb begin
        ord_nxt = ord_q;
        for (int k = 0; k < NUM_THREADS - 1; k++) begin
            if (k >= int'(pos)) ord_nxt[k] = ord_q[k+1];
        end
        ord_nxt[NUM_THREADS-1] = ord_q[pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_THREADS; k++) ord_q[k] <= TID_W'(k);
        end else if (advance_i && vld_o) begin
            ord_q <= ord_nxt;
        end
    end

    logic [NUM_THREADS-1:0] seen;
    always_comb begin
        seen = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            if (int'(ord_q[k]) < NUM_THREADS) seen[ord_q[k]] = 1'b1;
        end
    end

    assert_list_perm_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(seen) == NUM_THREADS);

    assert_list_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(advance_i && vld_o) |=> $stable(ord_q));

endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
    import csel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 16
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic [1:0]                                 policy_i,
    input  logic                                       req_i,
    input  logic [NUM_THREADS-1:0]                     active_i,
    input  logic [NUM_THREADS-1:0][STATUS_W-1:0]       status_i,
    input  logic [NUM_THREADS-1:0]                     empty_i,
    input  logic [NUM_THREADS-1:0]                     head_rdy_i,
    input  logic [NUM_THREADS-1:0][SEQ_W-1:0]          head_seq_i,
    output logic                                       grant_vld_o,
    output logic [tid_width(NUM_THREADS)-1:0]          grant_tid_o
);
    localparam int  TID_W  = tid_width(NUM_THREADS);
    localparam bit  MULTI  = (NUM_THREADS > 1);

    logic [NUM_THREADS-1:0] cand;
    logic                   is_rot;

    assign is_rot = (policy_i == POL_ROTATE);

    csel_elig #(
        .NUM_THREADS (NUM_THREADS),
        .NEED_HEAD   (MULTI)
    ) u_elig (
        .active_i   (active_i),
        .status_i   (status_i),
        .empty_i    (empty_i),
        .head_rdy_i (head_rdy_i),
        .cand_o     (cand)
    );

    if (MULTI) begin : g_multi
        logic             old_vld, rot_vld;
        logic [TID_W-1:0] old_tid, rot_tid;

        csel_oldest #(
            .NUM_THREADS (NUM_THREADS),
            .SEQ_W       (SEQ_W),
            .TID_W       (TID_W)
        ) u_oldest (
            .cand_i (cand),
            .seq_i  (head_seq_i),
            .vld_o  (old_vld),
            .tid_o  (old_tid)
        );

        csel_rr #(
            .NUM_THREADS (NUM_THREADS),
            .TID_W       (TID_W)
        ) u_rr (
            .clk       (clk),
            .rst       (rst),
            .advance_i (req_i && is_rot),
            .cand_i    (cand),
            .vld_o     (rot_vld),
            .tid_o     (rot_tid)
        );

        assign grant_vld_o = is_rot ? rot_vld : old_vld;
        assign grant_tid_o = is_rot ? rot_tid : old_tid;

        // Port-level view of the oldest-head rule
        logic older_exists;
        logic any_qual;
        always_comb begin
            older_exists = 1'b0;
            any_qual     = 1'b0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (active_i[t] && status_can_commit(status_i[t]) &&
                    !empty_i[t] && head_rdy_i[t]) begin
                    any_qual = 1'b1;
                    if ((head_seq_i[t] < head_seq_i[grant_tid_o]) ||
                        ((head_seq_i[t] == head_seq_i[grant_tid_o]) &&
                         (t < int'(grant_tid_o))))
                        older_exists = 1'b1;
                end
            end
        end

        assert_head_ready_R2: assert property (@(posedge clk) disable iff (rst)
            grant_vld_o |-> (head_rdy_i[grant_tid_o] && !empty_i[grant_tid_o]));

        assert_oldest_pick_R3: assert property (@(posedge clk) disable iff (rst)
            (grant_vld_o && !is_rot) |-> !older_exists);

        assert_grant_when_any_R10: assert property (@(posedge clk) disable iff (rst)
            any_qual |-> grant_vld_o);
    end else begin : g_single
        assign grant_vld_o = cand[0];
        assign grant_tid_o = '0;

        assert_single_grant_R9: assert property (@(posedge clk) disable iff (rst)
            (active_i[0] && status_can_commit(status_i[0])) |-> grant_vld_o);
    end

    assert_grant_state_R1: assert property (@(posedge clk) disable iff (rst)
        grant_vld_o |-> (active_i[grant_tid_o] && status_can_commit(status_i[grant_tid_o])));

    assert_idle_index_R10: assert property (@(posedge clk) disable iff (rst)
        !grant_vld_o |-> (grant_tid_o == '0));

endmodule

// File: tb/commit_thread_sel_test.sv
module commit_thread_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT  = 4;
    localparam int SW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [1:0]           pol;
    logic                 req;
    logic [NT-1:0]        act, emp, rdy;
    logic [NT-1:0][2:0]   st;
    logic [NT-1:0][SW-1:0] sq;
    logic                 g_vld;
    logic [1:0]           g_tid;

    logic                 one_act, one_emp, one_rdy;
    logic [0:0][2:0]      one_st;
    logic [0:0][SW-1:0]   one_sq;
    logic                 o_vld;
    logic [0:0]           o_tid;

    commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) uut (
        .clk(clk), .rst(rst), .policy_i(pol), .req_i(req),
        .active_i(act), .status_i(st), .empty_i(emp), .head_rdy_i(rdy),
        .head_seq_i(sq), .grant_vld_o(g_vld), .grant_tid_o(g_tid));

    commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) uut_single (
        .clk(clk), .rst(rst), .policy_i(pol), .req_i(req),
        .active_i(one_act), .status_i(one_st), .empty_i(one_emp),
        .head_rdy_i(one_rdy), .head_seq_i(one_sq),
        .grant_vld_o(o_vld), .grant_tid_o(o_tid));

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int m_ord[NT];

    function automatic bit st_ok(input logic [2:0] s);
        return (s == 3'd0) || (s == 3'd1) || (s == 3'd4);
    endfunction

    function automatic bit is_cand(input int t);
        return act[t] && st_ok(st[t]) && !emp[t] && rdy[t];
    endfunction

    // Expected grant for the four-thread copy: {valid, index}
    function automatic int exp_grant(output bit v);
        int best = 0;
        v = 0;
        if (pol == 2'd1) begin
            for (int k = 0; k < NT; k++)
                if (!v && is_cand(m_ord[k])) begin v = 1; best = m_ord[k]; end
        end else begin
            for (int t = 0; t < NT; t++)
                if (is_cand(t) && (!v || sq[t] < sq[best])) begin v = 1; best = t; end
        end
        return best;
    endfunction

    task automatic check(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic rotate_model(input int tid);
        int p = 0;
        for (int k = 0; k < NT; k++) if (m_ord[k] == tid) p = k;
        for (int k = p; k < NT - 1; k++) m_ord[k] = m_ord[k+1];
        m_ord[NT-1] = tid;
    endtask

    // Inputs already set just after a falling edge
    task automatic step(input string tag);
        bit ev;
        int et;
        #2;
        et = exp_grant(ev);
        check({tag, " valid"}, int'(g_vld), int'(ev));
        check({tag, " tid"}, int'(g_tid), ev ? et : 0);
        check({tag, " single R9"}, int'(o_vld), int'(one_act && st_ok(one_st[0])));
        check({tag, " single tid R10"}, int'(o_tid), 0);
        if (pol == 2'd1 && req && ev) rotate_model(et);
        @(negedge clk);
    endtask

    task automatic all_ready();
        act = '1; emp = '0; rdy = '1;
        for (int t = 0; t < NT; t++) begin st[t] = 3'd1; sq[t] = SW'(100 + t); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        pol = 2'd1; req = 0;
        act = '0; emp = '1; rdy = '0; st = '0; sq = '0;
        one_act = 0; one_emp = 1; one_rdy = 0; one_st = '0; one_sq = '0;
        for (int k = 0; k < NT; k++) m_ord[k] = k;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: nothing qualifies
        step("R10 none");
        // R6: ascending order after reset
        all_ready();
        #2; check("R6 first after reset", int'(g_tid), 0); @(negedge clk);
        // R5/R7 rotation sequence 0,1,2,3,0
        req = 1;
        for (int i = 0; i < 5; i++) begin
            #1; check("R7 rotation order", int'(g_tid), i % NT); #1;
            if (g_vld) rotate_model(int'(g_tid));
            @(negedge clk);
        end
        // R5: skip non-candidates in list order (list now 1,2,3,0)
        rdy[1] = 0;
        #2; check("R5 skip not ready", int'(g_tid), 2); @(negedge clk);
        rotate_model(2);
        // R8: no req, list held
        req = 0; rdy[1] = 1;
        step("R8 no req a"); step("R8 no req b");
        #2; check("R8 held front", int'(g_tid), 1); @(negedge clk);
        // R8: other policy with req does not rotate
        pol = 2'd2; req = 1; step("R8 other policy");
        pol = 2'd1; req = 0;
        #2; check("R8 front after policy change", int'(g_tid), 1); @(negedge clk);
        // R3 with tie, R4 aggressive
        all_ready(); pol = 2'd2;
        sq[0] = 50; sq[1] = 20; sq[2] = 20; sq[3] = 70;
        #2; check("R3 oldest tie low index", int'(g_tid), 1); @(negedge clk);
        pol = 2'd0;
        #2; check("R4 aggressive same", int'(g_tid), 1); @(negedge clk);
        pol = 2'd3;
        #2; check("R3 spare code", int'(g_tid), 1); @(negedge clk);
        // R1: squash / trap states and inactive threads excluded
        pol = 2'd2; st[1] = 3'd2; st[2] = 3'd3;
        #2; check("R1 squash and trap skipped", int'(g_tid), 0); @(negedge clk);
        st[0] = 3'd4; act[0] = 0;
        #2; check("R1 inactive skipped", int'(g_tid), 3); @(negedge clk);
        act[0] = 1;
        #2; check("R1 fetch-trap eligible", int'(g_tid), 0); @(negedge clk);
        // R2: empty / not ready excluded
        all_ready(); emp[0] = 1; rdy[1] = 0;
        #2; check("R2 empty and not ready", int'(g_tid), 2); @(negedge clk);
        // R9: single thread ignores head flags
        one_act = 1; one_st[0] = 3'd1; one_emp = 1; one_rdy = 0;
        step("R9 head flags ignored");
        one_st[0] = 3'd3; step("R1 single trap");
        one_st[0] = 3'd0; one_act = 0; step("R1 single inactive");

        // Random mix
        for (int seg = 0; seg < 12; seg++) begin
            pol = 2'($urandom_range(0, 3));
            for (int i = 0; i < 250; i++) begin
                req = ($urandom_range(0, 3) != 0);
                for (int t = 0; t < NT; t++) begin
                    act[t] = ($urandom_range(0, 5) != 0);
                    st[t]  = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7))
                                                         : 3'($urandom_range(0, 1));
                    emp[t] = ($urandom_range(0, 4) == 0);
                    rdy[t] = ($urandom_range(0, 2) != 0);
                    sq[t]  = SW'($urandom_range(0, 7));
                end
                one_act = $urandom_range(0, 1);
                one_st[0] = 3'($urandom_range(0, 7));
                one_emp = $urandom_range(0, 1);
                one_rdy = $urandom_range(0, 1);
                step("RAND");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule